// File: doc/BRIEF.md
# Virtual Output Queue Buffer with Multicast Fanout Splitting

This block holds the cells that wait at one input port of an input-queued crossbar switch. Each unicast cell goes into its own FIFO, chosen by its destination output and its priority class. A cell that waits for a busy output therefore never holds back cells bound for other outputs. Multicast cells carry a bitmap of target outputs. They go into one FIFO per priority, apart from the unicast queues, and are served strictly in arrival order within that FIFO.

Towards the scheduler the block publishes two request vectors. One holds the non-empty flag of every unicast queue. The other holds, for each priority, the outputs that the multicast head cell still has to reach. The scheduler answers once per slot with a grant. The grant names either one unicast queue, or one multicast priority together with the outputs served in that slot. The block presents the granted cell in the same cycle. Multicast delivery is split over slots: served outputs are struck from the head cell's residual mask, and the cell leaves only once that mask is empty.

Top module: `voq_mcast_buf`

## Requirements
- R1: After reset every unicast and multicast request bit is 0 and cell_valid_o is 0.
- R2: Unicast queue (output o, priority p) drives request bit uc_req_o[p*N_OUT+o]. The bit is 1 exactly while that queue holds a cell. Queues are independent: draining one leaves every other bit unchanged.
- R3: Each unicast queue returns its cells in write order.
- R4: A write aimed at a queue that already holds DEPTH cells asserts wr_drop_o in that cycle, and the cell is discarded. This applies to unicast and multicast queues alike, even when the same queue is dequeued in that cycle. The stored contents stay unchanged.
- R5: mc_req_o[p*N_OUT +: N_OUT] equals the residual mask of the head cell of multicast priority p, and is 0 when that queue is empty. A freshly written head shows its full fanout.
- R6: A multicast grant with served mask S drives cell_valid_o=1, the head data, and cell_mask_o = S & residual in that cycle. From the next cycle the residual is the old residual with the bits of S cleared.
- R7: The multicast head leaves the queue in the cycle its residual becomes 0. The next cell's full fanout appears in the following cycle, and no later cell is presented before an earlier one.
- R8: A grant to an empty unicast queue gives cell_valid_o=0. So does a multicast grant whose served mask does not overlap the residual. Neither changes any request bit.
- R9: A write and a grant that hit the same non-full queue in one cycle are both carried out. This holds for unicast queues and for a multicast queue whose head leaves in that cycle.
- R10: A multicast write with an all-zero fanout is discarded and asserts wr_drop_o.
- R11: A unicast grant to a non-empty queue gives cell_valid_o=1, the head data, and cell_mask_o one-hot at the queue's output, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Cell write strobe |
| wr_mcast_i | input | 1 | Written cell is multicast |
| wr_dest_i | input | OUT_W | Destination output of a unicast write |
| wr_prio_i | input | PRIO_W | Priority class of the write |
| wr_fanout_i | input | N_OUT | Target outputs of a multicast write |
| wr_data_i | input | DATA_W | Cell payload |
| wr_drop_o | output | 1 | Write discarded this cycle |
| gnt_valid_i | input | 1 | Grant strobe for this slot |
| gnt_mcast_i | input | 1 | Grant targets a multicast queue |
| gnt_dest_i | input | OUT_W | Output of a unicast grant |
| gnt_prio_i | input | PRIO_W | Priority of the granted queue |
| gnt_fanout_i | input | N_OUT | Outputs served by a multicast grant |
| uc_req_o | output | N_OUT*N_PRIO | Unicast non-empty flags, bit p*N_OUT+o |
| mc_req_o | output | N_OUT*N_PRIO | Multicast residual masks, slice p |
| cell_valid_o | output | 1 | A cell is sent this cycle |
| cell_data_o | output | DATA_W | Payload of the sent cell |
| cell_mask_o | output | N_OUT | Outputs receiving a copy this cycle |

## Verification
Two pairs of events can land in the same cycle. The first is an enqueue and a dequeue on one queue. The second is the removal of a multicast head and the arrival of the cell that becomes the new head. The bench provokes both by driving a write and a grant to the same queue together. In the multicast case the queue holds a single cell whose last pending output is being served. The bench judges the result by the payload presented in that cycle and by the request vector that follows it. A full queue receiving a write during a grant is also checked: the drop must win.

// File: rtl/voq_pkg.sv
package voq_pkg;
  localparam int VOQ_OUTS   = 4;
  localparam int VOQ_PRIOS  = 4;
  localparam int VOQ_DEPTH  = 4;
  localparam int VOQ_DATA_W = 16;
endpackage

// File: rtl/voq_fifo.sv
module voq_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic [WIDTH-1:0] nxt_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             multi_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q, rd_nx;
  logic [CNT_W-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign multi_o = (cnt_q > CNT_W'(1));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rd_nx   = (rd_q == LAST) ? '0 : rd_q + 1'b1;
  assign dout_o  = mem_q[rd_q];
  assign nxt_o   = mem_q[rd_nx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_nx;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  // caller must gate writes to a full queue
  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/voq_mc_queue.sv
module voq_mc_queue #(
  parameter int DATA_W = 16,
  parameter int N_OUT  = 4,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [N_OUT-1:0]  fan_i,
  input  logic              gnt_i,
  input  logic [N_OUT-1:0]  served_i,
  output logic [DATA_W-1:0] head_o,
  output logic [N_OUT-1:0]  res_o,
  output logic              hit_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int W = DATA_W + N_OUT;

  logic [W-1:0]     head_w, nxt_w;
  logic [N_OUT-1:0] res_q, left_w;
  logic             multi_w, pop_w;

  voq_fifo #(.WIDTH(W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_i),
    .din_i   ({fan_i, data_i}),
    .pop_i   (pop_w),
    .dout_o  (head_w),
    .nxt_o   (nxt_w),
    .empty_o (empty_o),
    .full_o  (full_o),
    .multi_o (multi_w)
  );

  assign head_o = head_w[DATA_W-1:0];
  assign res_o  = res_q;
  assign left_w = res_q & ~served_i;
  assign hit_o  = gnt_i && !empty_o && |(res_q & served_i);
  assign pop_w  = hit_o && (left_w == '0);

  // residual mask of the head cell; reloaded when a new cell becomes head
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 res_q <= '0;
    else if (pop_w) begin
      if (multi_w)               res_q <= nxt_w[W-1:DATA_W];
      else if (push_i)           res_q <= fan_i;
      else                       res_q <= '0;
    end
    else if (hit_o)              res_q <= left_w;
    else if (empty_o && push_i)  res_q <= fan_i;
  end

  assert_res_live_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o == (res_q == '0));
  assert_res_shrink_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !pop_w) |=> ((res_q & ~$past(res_q)) == '0) && (res_q != $past(res_q)));
endmodule

// File: rtl/voq_mcast_buf.sv
module voq_mcast_buf
  import voq_pkg::*;
#(
  parameter int N_OUT  = VOQ_OUTS,
  parameter int N_PRIO = VOQ_PRIOS,
  parameter int DEPTH  = VOQ_DEPTH,
  parameter int DATA_W = VOQ_DATA_W,
  localparam int OUT_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int PRIO_W = (N_PRIO > 1) ? $clog2(N_PRIO) : 1,
  localparam int N_UQ   = N_OUT * N_PRIO
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic              wr_mcast_i,
  input  logic [OUT_W-1:0]  wr_dest_i,
  input  logic [PRIO_W-1:0] wr_prio_i,
  input  logic [N_OUT-1:0]  wr_fanout_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_drop_o,
  input  logic              gnt_valid_i,
  input  logic              gnt_mcast_i,
  input  logic [OUT_W-1:0]  gnt_dest_i,
  input  logic [PRIO_W-1:0] gnt_prio_i,
  input  logic [N_OUT-1:0]  gnt_fanout_i,
  output logic [N_UQ-1:0]   uc_req_o,
  output logic [N_UQ-1:0]   mc_req_o,
  output logic              cell_valid_o,
  output logic [DATA_W-1:0] cell_data_o,
  output logic [N_OUT-1:0]  cell_mask_o
);
  localparam int IDX_W = OUT_W + PRIO_W;

  logic [IDX_W-1:0]  wr_idx, gnt_idx;
  logic [N_UQ-1:0]   uc_empty, uc_full, uc_push;
  logic [DATA_W-1:0] uc_head [N_UQ];
  logic [DATA_W-1:0] uc_nxt  [N_UQ];
  logic [N_UQ-1:0]   uc_multi;
  logic [N_PRIO-1:0] mc_empty, mc_full, mc_hit, mc_push;
  logic [DATA_W-1:0] mc_head [N_PRIO];
  logic [N_OUT-1:0]  mc_res  [N_PRIO];

  // queue index = priority * N_OUT + output (sizes are powers of two)
  assign wr_idx  = {wr_prio_i, wr_dest_i};
  assign gnt_idx = {gnt_prio_i, gnt_dest_i};

  for (genvar q = 0; q < N_UQ; q++) begin : g_uc
    assign uc_push[q] = wr_valid_i && !wr_mcast_i && (wr_idx == IDX_W'(q)) && !uc_full[q];
    voq_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_q (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (uc_push[q]),
      .din_i   (wr_data_i),
      .pop_i   (gnt_valid_i && !gnt_mcast_i && (gnt_idx == IDX_W'(q))),
      .dout_o  (uc_head[q]),
      .nxt_o   (uc_nxt[q]),
      .empty_o (uc_empty[q]),
      .full_o  (uc_full[q]),
      .multi_o (uc_multi[q])
    );
  end

  for (genvar p = 0; p < N_PRIO; p++) begin : g_mc
    assign mc_push[p] = wr_valid_i && wr_mcast_i && (wr_prio_i == PRIO_W'(p))
                        && !mc_full[p] && (wr_fanout_i != '0);
    voq_mc_queue #(.DATA_W(DATA_W), .N_OUT(N_OUT), .DEPTH(DEPTH)) u_q (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .push_i   (mc_push[p]),
      .data_i   (wr_data_i),
      .fan_i    (wr_fanout_i),
      .gnt_i    (gnt_valid_i && gnt_mcast_i && (gnt_prio_i == PRIO_W'(p))),
      .served_i (gnt_fanout_i),
      .head_o   (mc_head[p]),
      .res_o    (mc_res[p]),
      .hit_o    (mc_hit[p]),
      .empty_o  (mc_empty[p]),
      .full_o   (mc_full[p])
    );
    assign mc_req_o[p*N_OUT +: N_OUT] = mc_res[p];
  end

  assign uc_req_o = ~uc_empty;

  always_comb begin
    wr_drop_o = 1'b0;
    if (wr_valid_i) begin
      if (wr_mcast_i) wr_drop_o = mc_full[wr_prio_i] || (wr_fanout_i == '0);
      else            wr_drop_o = uc_full[wr_idx];
    end
  end

  always_comb begin
    cell_valid_o = 1'b0;
    cell_data_o  = '0;
    cell_mask_o  = '0;
    if (gnt_valid_i) begin
      if (gnt_mcast_i) begin
        cell_valid_o = mc_hit[gnt_prio_i];
        cell_data_o  = mc_head[gnt_prio_i];
        cell_mask_o  = gnt_fanout_i & mc_res[gnt_prio_i];
      end else if (!uc_empty[gnt_idx]) begin
        cell_valid_o = 1'b1;
        cell_data_o  = uc_head[gnt_idx];
        cell_mask_o  = N_OUT'(1) << gnt_dest_i;
      end
    end
  end

  assert_uc_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((uc_req_o & ~$past(uc_req_o)) != '0) |-> $past(wr_valid_i && !wr_mcast_i));
  assert_uc_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~uc_req_o & $past(uc_req_o)) != '0) |-> $past(gnt_valid_i && !gnt_mcast_i));
  assert_uc_cell_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_valid_o && !gnt_mcast_i) |-> $onehot(cell_mask_o));
  assert_drop_nopush_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_drop_o |-> (uc_push == '0) && (mc_push == '0));
endmodule

// File: tb/voq_mcast_buf_tb.sv
module voq_mcast_buf_tb;
  localparam int NO = 4, NP = 4, DP = 4, DW = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_valid_i = 0, wr_mcast_i = 0, gnt_valid_i = 0, gnt_mcast_i = 0;
  logic [1:0] wr_dest_i = 0, wr_prio_i = 0, gnt_dest_i = 0, gnt_prio_i = 0;
  logic [NO-1:0] wr_fanout_i = 0, gnt_fanout_i = 0;
  logic [DW-1:0] wr_data_i = 0;
  logic wr_drop_o, cell_valid_o;
  logic [NO*NP-1:0] uc_req_o, mc_req_o;
  logic [DW-1:0] cell_data_o;
  logic [NO-1:0] cell_mask_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  voq_mcast_buf #(.N_OUT(NO), .N_PRIO(NP), .DEPTH(DP), .DATA_W(DW)) u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    wr_valid_i = 0; wr_mcast_i = 0; gnt_valid_i = 0; gnt_mcast_i = 0;
    wr_fanout_i = 0; gnt_fanout_i = 0;
    #1;
  endtask

  task automatic wr_uc(int o, int p, int d);
    wr_valid_i = 1; wr_mcast_i = 0; wr_dest_i = 2'(o); wr_prio_i = 2'(p); wr_data_i = 16'(d);
  endtask
  task automatic wr_mc(int p, int f, int d);
    wr_valid_i = 1; wr_mcast_i = 1; wr_prio_i = 2'(p); wr_fanout_i = 4'(f); wr_data_i = 16'(d);
  endtask
  task automatic gn_uc(int o, int p);
    gnt_valid_i = 1; gnt_mcast_i = 0; gnt_dest_i = 2'(o); gnt_prio_i = 2'(p);
  endtask
  task automatic gn_mc(int p, int f);
    gnt_valid_i = 1; gnt_mcast_i = 1; gnt_prio_i = 2'(p); gnt_fanout_i = 4'(f);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp;
    #25 rst_ni = 1;
    @(negedge clk_i); #1;
    chk("R1 uc_req", 32'(uc_req_o), 0);
    chk("R1 mc_req", 32'(mc_req_o), 0);
    chk("R1 cell_valid", 32'(cell_valid_o), 0);

    // R2: fill every unicast queue with one cell
    exp = 0;
    for (int p = 0; p < NP; p++)
      for (int o = 0; o < NO; o++) begin
        wr_uc(o, p, 'h1000 + p*16 + o); #1;
        chk("R4 no drop", 32'(wr_drop_o), 0);
        step();
        exp[p*NO+o] = 1'b1;
        chk("R2 uc_req set", 32'(uc_req_o), 32'(exp));
      end
    // R2/R11: drain in reverse order, other bits untouched
    for (int q = NO*NP-1; q >= 0; q--) begin
      gn_uc(q % NO, q / NO); #1;
      chk("R11 valid", 32'(cell_valid_o), 1);
      chk("R11 data", 32'(cell_data_o), 32'('h1000 + (q/NO)*16 + q%NO));
      chk("R11 mask", 32'(cell_mask_o), 32'(1 << (q % NO)));
      step();
      exp[q] = 1'b0;
      chk("R2 uc_req clear", 32'(uc_req_o), 32'(exp));
    end

    // R4/R3: fill queue (1,2), overflow, drain in order
    for (int k = 0; k < DP; k++) begin wr_uc(1, 2, 'h200 + k); step(); end
    wr_uc(1, 2, 'h2FF); gn_uc(1, 2); #1;
    chk("R4 drop on full", 32'(wr_drop_o), 1);
    step();
    for (int k = 1; k < DP; k++) begin
      gn_uc(1, 2); #1;
      chk("R3 order", 32'(cell_data_o), 32'('h200 + k));
      step();
    end
    chk("R4 dropped cell absent", 32'(uc_req_o), 0);
    gn_uc(1, 2); #1;
    chk("R8 empty grant", 32'(cell_valid_o), 0);
    step();

    // R9: simultaneous enqueue/dequeue on unicast queue
    wr_uc(3, 0, 'hA1); step();
    wr_uc(3, 0, 'hB2); gn_uc(3, 0); #1;
    chk("R9 head out", 32'(cell_data_o), 'hA1);
    step();
    chk("R9 still queued", 32'(uc_req_o), 32'(1 << 3));
    gn_uc(3, 0); #1;
    chk("R9 second cell", 32'(cell_data_o), 'hB2);
    step();
    chk("R9 empty", 32'(uc_req_o), 0);

    // R5-R8: multicast fanout splitting
    wr_mc(1, 'b1011, 'hC1); step();
    wr_mc(1, 'b0110, 'hC2); step();
    chk("R5 head fanout", 32'(mc_req_o[4 +: 4]), 'b1011);
    gn_mc(1, 'b0011); #1;
    chk("R6 valid", 32'(cell_valid_o), 1);
    chk("R6 data", 32'(cell_data_o), 'hC1);
    chk("R6 mask", 32'(cell_mask_o), 'b0011);
    step();
    chk("R6 residual", 32'(mc_req_o[4 +: 4]), 'b1000);
    gn_mc(1, 'b0100); #1;
    chk("R8 no overlap", 32'(cell_valid_o), 0);
    step();
    chk("R8 residual kept", 32'(mc_req_o[4 +: 4]), 'b1000);
    gn_mc(1, 'b1111); #1;
    chk("R7 last copy data", 32'(cell_data_o), 'hC1);
    chk("R6 last copy mask", 32'(cell_mask_o), 'b1000);
    step();
    chk("R7 next head", 32'(mc_req_o[4 +: 4]), 'b0110);
    gn_mc(1, 'b0110); #1;
    chk("R7 order", 32'(cell_data_o), 'hC2);
    step();
    chk("R7 mc empty", 32'(mc_req_o), 0);

    // R10: zero fanout
    wr_mc(0, 0, 'hD0); #1;
    chk("R10 drop", 32'(wr_drop_o), 1);
    step();
    chk("R10 discarded", 32'(mc_req_o), 0);

    // R9: multicast head leaves while new cell arrives
    wr_mc(3, 'b0001, 'hE1); step();
    wr_mc(3, 'b1100, 'hE2); gn_mc(3, 'b0001); #1;
    chk("R9 mc head", 32'(cell_data_o), 'hE1);
    step();
    chk("R9 mc new head", 32'(mc_req_o[12 +: 4]), 'b1100);
    gn_mc(3, 'b1100); #1;
    chk("R9 mc data", 32'(cell_data_o), 'hE2);
    step();
    chk("R9 mc empty", 32'(mc_req_o), 0);

    // R4: multicast overflow
    for (int k = 0; k < DP; k++) begin wr_mc(2, 'b0001, 'hF0 + k); step(); end
    wr_mc(2, 'b0010, 'hFF); #1;
    chk("R4 mc drop", 32'(wr_drop_o), 1);
    step();
    for (int k = 0; k < DP; k++) begin
      gn_mc(2, 'b1111); #1;
      chk("R4 mc kept", 32'(cell_data_o), 32'('hF0 + k));
      step();
    end
    chk("R4 mc drained", 32'(mc_req_o), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule